// File: doc/BRIEF.md
# Serial Vacuum Fluorescent Display Driver Core

This block is the logic core of a cascadable serial driver for a multiplexed vacuum fluorescent display. A host shifts a 32-bit frame into the device one bit per rising edge of a serial clock. A level-sensitive strobe copies the frame into a holding latch. The latch bits are routed to 29 anode enables and 3 grid enables.

The grid enables pass through a common grid gate, so the host can blank the tube between multiplex steps without reloading data. The anode enables are never gated. The last stage of the shift register leaves the device on a serial output that changes only on falling clock edges. This lets several devices share one clock and one strobe in a daisy chain with no hold-time race.

An asynchronous active-low reset clears the shift register, the latch and the serial output. All outputs then stay off until the first strobe that follows a load.

Top module: `vfd_serial_driver`

## Requirements
- R1: On each rising edge of `sclk` the 32-bit shift register takes `sdi` into its first stage. The first bit of a frame (frame bit 1) reaches the last stage after 32 rising edges. Frame bit k is the bit clocked in k-th of 32.
- R2: `sdo` takes the value of the last shift-register stage on each falling edge of `sclk` and changes at no other time except reset. A bit that reaches the last stage on a rising edge therefore appears on `sdo` half a clock later.
- R3: While `strobe` is 1 the latch follows the shift register, including bits shifted in during that time. While `strobe` is 0 the latch and all outputs hold, even while new data shifts in.
- R4: A latch value of 1 turns an output on and 0 turns it off. Frame bits 1 to 8 drive `anode_on[0..7]` (anodes 1 to 8). Frame bit k for k = 9..16 drives anode 25−k, and for k = 17..23 drives anode 40−k. Frame bits 25 to 30 drive anodes 24 to 29. Anode n is `anode_on[n-1]`.
- R5: Frame bit 31 drives `grid_on[0]`, bit 32 drives `grid_on[1]` and bit 24 drives `grid_on[2]`. All three are ANDed with `grid_en`. `grid_en` has no effect on `anode_on`.
- R6: While `rst_n` is 0, the shift register and latch are cleared and `sdo`, `anode_on` and `grid_on` are 0. `sdo` stays 0 until the first falling edge after release.
- R7: Two devices chained `sdo` to `sdi`, sharing clock and strobe, take a 64-bit stream in 64 rising edges. After one strobe the downstream device shows stream bits 1 to 32 and the upstream device shows bits 33 to 64, each under the mapping of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial data input |
| strobe | input | 1 | Latch transparent while high |
| grid_en | input | 1 | Grid output gate, active high |
| sdo | output | 1 | Serial cascade output, falling-edge timed |
| anode_on | output | 29 | Anode enables, anode n at bit n-1 |
| grid_on | output | 3 | Grid enables, grid n at bit n-1 |

## Verification
The bench drives a walking one through every frame position. A wrong or missing reversal in the two reversed anode ranges, or a swapped pair of grids, lights the wrong output. It also shifts a fresh frame with the strobe low: a latch that is not a true hold shows the new pattern early. With the strobe held high it checks that the outputs follow each shift, which an edge-captured latch would miss. It checks that `sdo` is still the old value just after the rising edge and has the new value after the falling one: a rising-edge output would move a half-cycle early and a two-device chain would lose a bit. Grid gating is toggled with the anodes lit, to show that only the grids react. A reset in mid-run with a loaded frame must leave everything dark, including after a following strobe.

// File: rtl/vfd_serial_driver.sv
module vfd_serial_driver (
  input  logic        sclk,
  input  logic        rst_n,
  input  logic        sdi,
  input  logic        strobe,
  input  logic        grid_en,
  output logic        sdo,
  output logic [28:0] anode_on,
  output logic [2:0]  grid_on
);
  localparam int FRAME = 32;
  localparam int ANODES = 29;

  logic [FRAME-1:0] sr_q;
  logic [FRAME-1:0] lat_q;
  logic             sdo_q;

  // frame bit k sits at sr_q[FRAME-k] once a full frame is in
  function automatic int anode_src(int n);
    if (n <= 8)       return n;
    else if (n <= 16) return 25 - n;
    else if (n <= 23) return 40 - n;
    else              return n + 1;
  endfunction

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[FRAME-2:0], sdi};

  always_ff @(negedge sclk or negedge rst_n)
    if (!rst_n) sdo_q <= 1'b0;
    else        sdo_q <= sr_q[FRAME-1];

  always_latch
    if (!rst_n)      lat_q <= '0;
    else if (strobe) lat_q <= sr_q;

  generate
    for (genvar n = 1; n <= ANODES; n++) begin : g_anode
      localparam int SRC = FRAME - anode_src(n);
      assign anode_on[n-1] = lat_q[SRC];
    end
  endgenerate

  assign grid_on = {lat_q[FRAME-24], lat_q[FRAME-32], lat_q[FRAME-31]} & {3{grid_en}};
  assign sdo = sdo_q;
endmodule

module vfd_serial_driver_chk (
  input logic        sclk,
  input logic        rst_n,
  input logic        sdi,
  input logic        strobe,
  input logic        grid_en,
  input logic        sdo,
  input logic [28:0] anode_on,
  input logic [2:0]  grid_on,
  input logic [31:0] sr_q,
  input logic [31:0] lat_q
);
  a_r1_shift: assert property (@(posedge sclk) disable iff (!rst_n)
    $past(rst_n) |-> (sr_q == {$past(sr_q[30:0]), $past(sdi)}));

  a_r2_dout_fall: assert property (@(negedge sclk) disable iff (!rst_n)
    $past(rst_n) |-> (sdo == $past(sr_q[31])));

  a_r3_transparent: assert property (@(negedge sclk) disable iff (!rst_n)
    strobe |-> (lat_q == sr_q));

  a_r5_grid_gate: assert property (@(posedge sclk) disable iff (!rst_n)
    !grid_en |-> (grid_on == 3'b000));

  a_r6_reset_off: assert property (@(posedge sclk)
    !rst_n |-> (anode_on == '0 && grid_on == '0 && sdo == 1'b0));
endmodule

bind vfd_serial_driver vfd_serial_driver_chk chk_i (
  .sclk(sclk), .rst_n(rst_n), .sdi(sdi), .strobe(strobe), .grid_en(grid_en),
  .sdo(sdo), .anode_on(anode_on), .grid_on(grid_on), .sr_q(sr_q), .lat_q(lat_q)
);

// File: tb/vfd_serial_driver_tb.sv
module vfd_serial_driver_tb_top;
  logic clk = 1'b0, clk_en = 1'b0, rst_n = 1'b0;
  logic sdi = 1'b0, strobe = 1'b0, grid_en = 1'b1;
  logic sclk;
  logic sdo0, sdo1;
  logic [28:0] an0, an1;
  logic [2:0] gr0, gr1;
  int n_cmp = 0, n_bad = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;
  assign sclk = clk & clk_en;

  vfd_serial_driver dut_i (.sclk(sclk), .rst_n(rst_n), .sdi(sdi), .strobe(strobe),
    .grid_en(grid_en), .sdo(sdo0), .anode_on(an0), .grid_on(gr0));
  vfd_serial_driver dut_chain_i (.sclk(sclk), .rst_n(rst_n), .sdi(sdo0), .strobe(strobe),
    .grid_en(grid_en), .sdo(sdo1), .anode_on(an1), .grid_on(gr1));

  // reference model: q[0] newest bit, q[31] oldest; frame bit k at q[32-k]
  bit q0[$], q1[$];
  logic [32:1] l0 = '0, l1 = '0;
  logic d0 = 1'b0, d1 = 1'b0;

  task automatic model_clear();
    q0 = {}; q1 = {};
    repeat (32) begin q0.push_back(1'b0); q1.push_back(1'b0); end
    l0 = '0; l1 = '0; d0 = 1'b0; d1 = 1'b0;
  endtask

  initial model_clear();

  always @(posedge sclk) begin
    #1;
    if (rst_n) begin
      q1.push_front(d0); void'(q1.pop_back());
      q0.push_front(sdi); void'(q0.pop_back());
    end
  end

  always @(negedge sclk) begin
    #1;
    if (rst_n) begin d0 = q0[31]; d1 = q1[31]; end
  end

  always @(clk) begin
    #3;
    if (!rst_n) model_clear();
    else if (strobe)
      for (int k = 1; k <= 32; k++) begin l0[k] = q0[32-k]; l1[k] = q1[32-k]; end
  end

  function automatic logic [28:0] exp_an(logic [32:1] l);
    logic [28:0] r = '0;
    for (int k = 1; k <= 8; k++)   r[k-1]  = l[k];
    for (int k = 9; k <= 16; k++)  r[24-k] = l[k];
    for (int k = 17; k <= 23; k++) r[39-k] = l[k];
    for (int k = 25; k <= 30; k++) r[k-2]  = l[k];
    return r;
  endfunction

  function automatic logic [2:0] exp_gr(logic [32:1] l, logic en);
    return en ? {l[24], l[32], l[31]} : 3'b000;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(an0 == exp_an(l0), "R4 anodes dev0", {3'b0, an0}, {3'b0, exp_an(l0)});
    chk(gr0 == exp_gr(l0, grid_en), "R5 grids dev0", {29'b0, gr0}, {29'b0, exp_gr(l0, grid_en)});
    chk(sdo0 == d0, "R2 sdo dev0", {31'b0, sdo0}, {31'b0, d0});
    chk(an1 == exp_an(l1), "R7 anodes dev1", {3'b0, an1}, {3'b0, exp_an(l1)});
    chk(gr1 == exp_gr(l1, grid_en), "R7 grids dev1", {29'b0, gr1}, {29'b0, exp_gr(l1, grid_en)});
    chk(sdo1 == d1, "R7 sdo dev1", {31'b0, sdo1}, {31'b0, d1});
  endtask

  always @(posedge clk) begin #5; if (running) compare_all(); end
  always @(negedge clk) begin #5; if (running) compare_all(); end

  task automatic shift_bit(logic d);
    @(negedge clk); sdi = d; clk_en = 1'b1;
  endtask

  task automatic stop_clk();
    @(negedge clk); clk_en = 1'b0;
  endtask

  task automatic pulse_strobe();
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    @(posedge clk); #6;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete (R1..R7 unfinished)");
    finish_run();
  end

  initial begin
    logic [32:1] pat, onehot;
    logic [64:1] stream;
    logic [32:1] up, dn;
    // R6: reset state with clock running and random data
    clk_en = 1'b1;
    repeat (4) begin @(negedge clk); sdi = 1'($urandom); end
    @(posedge clk); #5;
    chk(an0 == '0 && gr0 == '0 && sdo0 == 1'b0, "R6 reset outputs", {an0, gr0}, 32'h0);
    @(negedge clk); clk_en = 1'b0; rst_n = 1'b1; sdi = 1'b0;
    running = 1'b1;
    @(posedge clk); #5;
    chk(sdo0 == 1'b0 && an0 == '0, "R6 after release", {31'b0, sdo0}, 32'h0);

    // R2: bit 1 = 1 reaches the last stage on edge 32, sdo follows half a clock later
    for (int i = 1; i <= 32; i++) shift_bit(i == 1);
    @(posedge clk); #5;
    chk(sdo0 == 1'b0, "R2 sdo before fall", {31'b0, sdo0}, 32'h0);
    @(negedge clk); clk_en = 1'b0; #5;
    chk(sdo0 == 1'b1, "R2 sdo after fall", {31'b0, sdo0}, 32'h1);

    // R4/R5: walking one through each frame position
    for (int b = 1; b <= 32; b++) begin
      for (int i = 1; i <= 32; i++) shift_bit(i == b);
      stop_clk();
      pulse_strobe();
      onehot = '0; onehot[b] = 1'b1;
      chk(an0 == exp_an(onehot), "R4 walking one anodes", {3'b0, an0}, {3'b0, exp_an(onehot)});
      chk(gr0 == exp_gr(onehot, 1'b1), "R5 walking one grids", {29'b0, gr0}, {29'b0, exp_gr(onehot, 1'b1)});
    end

    // R3: hold while new data shifts with strobe low
    pat = 32'hA5C3_96F1;
    for (int i = 1; i <= 32; i++) shift_bit(pat[i]);
    stop_clk();
    pulse_strobe();
    for (int i = 1; i <= 32; i++) shift_bit(~pat[i]);
    stop_clk();
    @(posedge clk); #6;
    chk(an0 == exp_an(pat), "R3 hold anodes", {3'b0, an0}, {3'b0, exp_an(pat)});
    chk(gr0 == exp_gr(pat, 1'b1), "R3 hold grids", {29'b0, gr0}, {29'b0, exp_gr(pat, 1'b1)});

    // R3: transparency, outputs follow shifts while strobe high
    @(negedge clk); strobe = 1'b1;
    for (int i = 0; i < 5; i++) shift_bit(i[0]);
    stop_clk();
    @(posedge clk); #6;
    chk(an0 == exp_an(l0) && l0 != ~pat, "R3 transparent follow", {3'b0, an0}, {3'b0, exp_an(l0)});
    @(negedge clk); strobe = 1'b0;

    // R5: grid gate affects only grids
    pat = '0; pat[24] = 1'b1; pat[31] = 1'b1; pat[32] = 1'b1; pat[5] = 1'b1; pat[12] = 1'b1;
    for (int i = 1; i <= 32; i++) shift_bit(pat[i]);
    stop_clk();
    pulse_strobe();
    chk(gr0 == 3'b111, "R5 grids enabled", {29'b0, gr0}, 32'h7);
    @(negedge clk); grid_en = 1'b0;
    @(posedge clk); #6;
    chk(gr0 == 3'b000, "R5 grids gated", {29'b0, gr0}, 32'h0);
    chk(an0 == exp_an(pat), "R5 anodes ungated", {3'b0, an0}, {3'b0, exp_an(pat)});
    @(negedge clk); grid_en = 1'b1;

    // R7: 64-bit stream into the two-device chain
    stream = {32'h1357_9BDF, 32'hC0FF_EE42};
    for (int i = 1; i <= 64; i++) shift_bit(stream[i]);
    stop_clk();
    pulse_strobe();
    for (int k = 1; k <= 32; k++) begin dn[k] = stream[k]; up[k] = stream[32+k]; end
    chk(an1 == exp_an(dn), "R7 downstream anodes", {3'b0, an1}, {3'b0, exp_an(dn)});
    chk(gr1 == exp_gr(dn, 1'b1), "R7 downstream grids", {29'b0, gr1}, {29'b0, exp_gr(dn, 1'b1)});
    chk(an0 == exp_an(up), "R7 upstream anodes", {3'b0, an0}, {3'b0, exp_an(up)});
    chk(gr0 == exp_gr(up, 1'b1), "R7 upstream grids", {29'b0, gr0}, {29'b0, exp_gr(up, 1'b1)});

    // R6: mid-run reset clears latch and register
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #6;
    chk(an0 == '0 && gr0 == '0 && an1 == '0, "R6 mid-run reset", {an0, gr0}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    pulse_strobe();
    chk(an0 == '0 && gr0 == '0 && sdo0 == 1'b0, "R6 strobe after reset", {an0, gr0}, 32'h0);

    repeat (3) @(posedge clk);
    #6;
    running = 1'b0;
    finish_run();
  end
endmodule